// File: doc/BRIEF.md
# ADC Power-Up Sequencer

This controller owns the power state of an analog-to-digital converter. Software drives a single write port carrying a three-bit power field (reference, bandgap and analog core), an enable bit, an external-reference select and a soft-reset bit. The three power domains only ever switch as a group: a write that tries to leave them in a mixed state is thrown away and recorded in a sticky error flag.

When the domains turn on, a settle counter sized from the clock-frequency parameter measures one millisecond. The block reports ready only once the domains are on, the converter is enabled and that interval has elapsed. Conversion requests are then either passed on as a start pulse or refused with a reject pulse. A calibration-required flag comes up after every hard or soft reset and stays up until the calibration routine reports completion. Power is changed only by these writes. No device-level low-power input exists.

Top module: `adc_pwrseq`

## Requirements
- R1: After hard reset, pwr_o is 3'b000, and enable_o, extref_o, ready_o, conv_start_o, conv_reject_o and partial_err_o are all 0, while cal_req_o is 1.
- R2: A write with no soft reset and cfg_pwr_i = 3'b111 sets pwr_o to 3'b111 at the clock edge that takes the write. A write with cfg_pwr_i = 3'b000 clears all three bits at that same edge. Bit 0 is the reference, bit 1 the bandgap and bit 2 the analog core.
- R3: Every accepted write (power field 3'b000 or 3'b111, no soft reset) loads enable_o from cfg_enable_i and extref_o from cfg_extref_i. The select may be set while powered off or in the same write that powers on.
- R4: ready_o stays low until SETTLE_CYCLES = (CLK_HZ/1000)*SETTLE_US/1000 clock edges have passed since the edge at which pwr_o went from off to on. It rises at exactly that edge when enable is set. A further power-on write while already on does not restart the count.
- R5: Powering down cancels the settle count. After power returns, a full SETTLE_CYCLES wait applies again.
- R6: ready_o equals power on AND enable_o AND settle expired. Clearing enable drops ready_o at the next edge. Setting it again restores ready_o at once, without a new wait.
- R7: A conv_req_i sampled at an edge while ready_o is 1 gives a one-cycle conv_start_o after that edge. When ready_o is 0 it gives conv_reject_o instead.
- R8: A write whose power field is neither 3'b000 nor 3'b111 sets partial_err_o and changes none of pwr_o, enable_o or extref_o. partial_err_o then stays set until a reset.
- R9: A write with cfg_softrst_i = 1 returns every output to its R1 value, whatever the other fields carry.
- R10: cal_done_i clears cal_req_o at the next edge, unless a soft-reset write arrives in the same cycle. In that case cal_req_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hard reset |
| cfg_wr_i | input | 1 | Control write strobe |
| cfg_pwr_i | input | 3 | Power field: [0] reference, [1] bandgap, [2] analog core |
| cfg_enable_i | input | 1 | Converter enable field |
| cfg_extref_i | input | 1 | External reference select field |
| cfg_softrst_i | input | 1 | Soft reset field |
| cal_done_i | input | 1 | Calibration routine finished |
| conv_req_i | input | 1 | Conversion request |
| pwr_o | output | 3 | Power controls of the three domains |
| enable_o | output | 1 | Converter enabled |
| extref_o | output | 1 | External reference selected |
| ready_o | output | 1 | Conversions may start |
| conv_start_o | output | 1 | Accepted conversion pulse |
| conv_reject_o | output | 1 | Refused conversion pulse |
| partial_err_o | output | 1 | Sticky flag for a mixed power write |
| cal_req_o | output | 1 | Calibration must be redone |

## Verification
Some properties are checked on every cycle by the assertions. The power controls are never mixed. A discarded partial write leaves power unchanged and latches the error. The error stays set until a reset. A soft reset forces the reset values. Ready never shows while the settle count is non-zero, and a power-down clears that count. Ready implies power and enable. Every request gives exactly one of start or reject.

Other behaviour can only be shown by the bench's scenarios. These are the exact edge at which ready rises after power-on, the fact that a repeated power-on write does not restart the count, a full new wait after a power cycle, instant recovery when enable is toggled, and the priority of soft reset over calibration-done.

// File: rtl/adc_pwrseq_pkg.sv
package adc_pwrseq_pkg;

    localparam int unsigned NUM_DOMAINS = 3;

    typedef logic [NUM_DOMAINS-1:0] pwr_vec_t;

    typedef enum logic [1:0] {
        CMD_IDLE    = 2'd0,
        CMD_SOFTRST = 2'd1,
        CMD_PARTIAL = 2'd2,
        CMD_APPLY   = 2'd3
    } cmd_kind_e;

    typedef struct packed {
        pwr_vec_t pwr;
        logic     en;
        logic     extref;
        logic     err;
        logic     cal_req;
    } ctrl_state_t;

    localparam ctrl_state_t CTRL_RESET = '{pwr: '0, en: 1'b0, extref: 1'b0,
                                           err: 1'b0, cal_req: 1'b1};

    function automatic logic pwr_uniform(input pwr_vec_t p);
        return (p == '0) || (&p);
    endfunction

    function automatic cmd_kind_e classify(input logic wr, input logic srst,
                                           input pwr_vec_t p);
        if (!wr)                 return CMD_IDLE;
        else if (srst)           return CMD_SOFTRST;
        else if (!pwr_uniform(p)) return CMD_PARTIAL;
        else                     return CMD_APPLY;
    endfunction

endpackage

// File: rtl/adc_pwrseq_ctrl.sv
module adc_pwrseq_ctrl
    import adc_pwrseq_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        wr_i,
    input  pwr_vec_t    pwr_i,
    input  logic        en_i,
    input  logic        extref_i,
    input  logic        softrst_i,
    input  logic        cal_done_i,
    output ctrl_state_t state_o,
    output logic        pwr_on_d_o,
    output logic        pwr_rise_o
);

    ctrl_state_t st_d, st_q;
    cmd_kind_e   cmd;

    always_comb begin
        cmd  = classify(wr_i, softrst_i, pwr_i);
        st_d = st_q;
        if (cal_done_i) begin
            st_d.cal_req = 1'b0;
        end
        unique case (cmd)
            CMD_SOFTRST: st_d = CTRL_RESET;
            CMD_PARTIAL: st_d.err = 1'b1;
            CMD_APPLY: begin
                st_d.pwr    = pwr_i;
                st_d.en     = en_i;
                st_d.extref = extref_i;
            end
            default: ;
        endcase
        pwr_on_d_o = &st_d.pwr;
        pwr_rise_o = (&st_d.pwr) && !(&st_q.pwr);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= CTRL_RESET;
        else         st_q <= st_d;
    end

    assign state_o = st_q;

    assert_pwr_uniform_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwr_uniform(st_q.pwr));

    assert_partial_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && !softrst_i && !pwr_uniform(pwr_i)) |=> ($stable(st_q.pwr) && st_q.err));

    assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.err && !(wr_i && softrst_i)) |=> st_q.err);

    assert_softrst_state_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && softrst_i) |=> (st_q.cal_req && st_q.pwr == '0 && !st_q.en && !st_q.err));

endmodule

// File: rtl/adc_pwrseq_timer.sv
module adc_pwrseq_timer #(
    parameter int unsigned CYCLES = 100_000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pwr_on_d_i,
    input  logic pwr_rise_i,
    output logic done_o
);

    localparam int unsigned LOAD = (CYCLES < 1) ? 1 : CYCLES;
    localparam int unsigned CW   = $clog2(LOAD + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          armed;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d       = t_q;
        t_d.armed = pwr_on_d_i;
        if (!pwr_on_d_i) begin
            t_d.cnt = '0;
        end else if (pwr_rise_i) begin
            t_d.cnt = CW'(LOAD);
        end else if (t_q.cnt != '0) begin
            t_d.cnt = t_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) t_q <= '0;
        else         t_q <= t_d;
    end

    assign done_o = t_q.armed && (t_q.cnt == '0);

    assert_no_early_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (t_q.cnt != '0) |-> !done_o);

    assert_cancel_on_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pwr_on_d_i |=> (!done_o && t_q.cnt == '0));

endmodule

// File: rtl/adc_pwrseq_gate.sv
module adc_pwrseq_gate (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    input  logic ready_i,
    output logic start_o,
    output logic reject_o
);

    typedef struct packed {
        logic start;
        logic reject;
    } gate_t;

    gate_t g_d, g_q;

    always_comb begin
        g_d.start  = req_i && ready_i;
        g_d.reject = req_i && !ready_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) g_q <= '0;
        else         g_q <= g_d;
    end

    assign start_o  = g_q.start;
    assign reject_o = g_q.reject;

    assert_one_outcome_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i |=> (start_o != reject_o));

    assert_no_start_unready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !ready_i) |=> !start_o);

endmodule

// File: rtl/adc_pwrseq.sv
module adc_pwrseq
    import adc_pwrseq_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 100_000_000,
    parameter int unsigned SETTLE_US = 1000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       cfg_wr_i,
    input  logic [2:0] cfg_pwr_i,
    input  logic       cfg_enable_i,
    input  logic       cfg_extref_i,
    input  logic       cfg_softrst_i,
    input  logic       cal_done_i,
    input  logic       conv_req_i,
    output logic [2:0] pwr_o,
    output logic       enable_o,
    output logic       extref_o,
    output logic       ready_o,
    output logic       conv_start_o,
    output logic       conv_reject_o,
    output logic       partial_err_o,
    output logic       cal_req_o
);

    localparam int unsigned SETTLE_CYCLES = (CLK_HZ / 1000) * SETTLE_US / 1000;

    ctrl_state_t st;
    logic        pwr_on_d;
    logic        pwr_rise;
    logic        settled;
    logic        ready;

    adc_pwrseq_ctrl u_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (cfg_wr_i),
        .pwr_i      (cfg_pwr_i),
        .en_i       (cfg_enable_i),
        .extref_i   (cfg_extref_i),
        .softrst_i  (cfg_softrst_i),
        .cal_done_i (cal_done_i),
        .state_o    (st),
        .pwr_on_d_o (pwr_on_d),
        .pwr_rise_o (pwr_rise)
    );

    adc_pwrseq_timer #(.CYCLES(SETTLE_CYCLES)) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pwr_on_d_i (pwr_on_d),
        .pwr_rise_i (pwr_rise),
        .done_o     (settled)
    );

    assign ready = (&st.pwr) && st.en && settled;

    adc_pwrseq_gate u_gate (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .req_i    (conv_req_i),
        .ready_i  (ready),
        .start_o  (conv_start_o),
        .reject_o (conv_reject_o)
    );

    assign pwr_o         = st.pwr;
    assign enable_o      = st.en;
    assign extref_o      = st.extref;
    assign partial_err_o = st.err;
    assign cal_req_o     = st.cal_req;
    assign ready_o       = ready;

    assert_ready_qualified_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |-> ((&pwr_o) && enable_o));

    assert_ready_drops_on_down_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_wr_i && !cfg_softrst_i && cfg_pwr_i == 3'b000) |=> !ready_o);

endmodule

// File: tb/adc_pwrseq_test.sv
`timescale 1ns/1ps
module adc_pwrseq_test;

    localparam int unsigned CLK_HZ = 40_000;
    localparam int unsigned N      = (CLK_HZ / 1000) * 1000 / 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr = 1'b0, en = 1'b0, xr = 1'b0, srst = 1'b0, cdone = 1'b0, req = 1'b0;
    logic [2:0] pw = 3'b000;
    logic [2:0] pwr_o;
    logic       enable_o, extref_o, ready_o, start_o, reject_o, err_o, cal_o;
    int         nchk = 0;
    int         nfail = 0;

    always #2.5 clk = ~clk;

    adc_pwrseq #(.CLK_HZ(CLK_HZ), .SETTLE_US(1000)) uut (
        .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(wr), .cfg_pwr_i(pw),
        .cfg_enable_i(en), .cfg_extref_i(xr), .cfg_softrst_i(srst),
        .cal_done_i(cdone), .conv_req_i(req), .pwr_o(pwr_o),
        .enable_o(enable_o), .extref_o(extref_o), .ready_o(ready_o),
        .conv_start_o(start_o), .conv_reject_o(reject_o),
        .partial_err_o(err_o), .cal_req_o(cal_o)
    );

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
        end
        #1;
    endtask

    task automatic do_write(input logic [2:0] p, input logic e, input logic x, input logic s);
        @(negedge clk);
        wr = 1'b1; pw = p; en = e; xr = x; srst = s;
        @(posedge clk); #1;
        wr = 1'b0; srst = 1'b0;
    endtask

    task automatic do_req(output logic st, output logic rj);
        @(negedge clk);
        req = 1'b1;
        @(posedge clk); #1;
        req = 1'b0;
        st = start_o; rj = reject_o;
    endtask

    task automatic t_reset;
        check("R1 pwr", pwr_o, 3'b000);
        check("R1 flags", {enable_o, extref_o, ready_o, start_o, reject_o, err_o}, 6'b0);
        check("R1 cal_req", cal_o, 1'b1);
    endtask

    task automatic t_cal_done;
        @(negedge clk); cdone = 1'b1;
        @(posedge clk); #1; cdone = 1'b0;
        check("R10 cal cleared", cal_o, 1'b0);
    endtask

    task automatic t_extref_first;
        do_write(3'b000, 1'b0, 1'b1, 1'b0);
        check("R3 extref while off", {pwr_o, extref_o, enable_o}, {3'b000, 1'b1, 1'b0});
    endtask

    task automatic t_power_up;
        logic s, r;
        do_write(3'b111, 1'b1, 1'b1, 1'b0);
        check("R2 all on", pwr_o, 3'b111);
        check("R3 enable same write", {enable_o, extref_o}, 2'b11);
        check("R4 not ready at power-on", ready_o, 1'b0);
        do_req(s, r);
        check("R7 reject while settling", {s, r}, 2'b01);
        tick(N - 2);
        check("R4 not ready one edge early", ready_o, 1'b0);
        tick(1);
        check("R4 ready after settle", ready_o, 1'b1);
    endtask

    task automatic t_repeat_on;
        do_write(3'b111, 1'b1, 1'b1, 1'b0);
        check("R4 repeat power-on keeps ready", ready_o, 1'b1);
    endtask

    task automatic t_enable_toggle;
        do_write(3'b111, 1'b0, 1'b1, 1'b0);
        check("R6 ready drops with enable", ready_o, 1'b0);
        do_write(3'b111, 1'b1, 1'b1, 1'b0);
        check("R6 ready back at once", ready_o, 1'b1);
    endtask

    task automatic t_conv_ok;
        logic s, r;
        do_req(s, r);
        check("R7 start when ready", {s, r}, 2'b10);
        tick(1);
        check("R7 start is one pulse", {start_o, reject_o}, 2'b00);
    endtask

    task automatic t_partial;
        do_write(3'b101, 1'b0, 1'b0, 1'b0);
        check("R8 err set", err_o, 1'b1);
        check("R8 state unchanged", {pwr_o, enable_o, extref_o, ready_o}, {3'b111, 3'b111});
        do_write(3'b111, 1'b1, 1'b1, 1'b0);
        check("R8 err sticky", err_o, 1'b1);
    endtask

    task automatic t_power_cycle;
        logic s, r;
        do_write(3'b000, 1'b1, 1'b1, 1'b0);
        check("R2 all off", {pwr_o, ready_o}, 4'b0000);
        do_req(s, r);
        check("R7 reject while off", {s, r}, 2'b01);
        do_write(3'b111, 1'b1, 1'b1, 1'b0);
        tick(N / 2);
        do_write(3'b000, 1'b1, 1'b1, 1'b0);
        do_write(3'b111, 1'b1, 1'b1, 1'b0);
        tick(N - 1);
        check("R5 full wait after power cycle", ready_o, 1'b0);
        tick(1);
        check("R5 ready after new wait", ready_o, 1'b1);
    endtask

    task automatic t_softrst;
        @(negedge clk);
        wr = 1'b1; pw = 3'b111; en = 1'b1; xr = 1'b1; srst = 1'b1; cdone = 1'b1;
        @(posedge clk); #1;
        wr = 1'b0; srst = 1'b0; cdone = 1'b0;
        check("R9 pwr off", pwr_o, 3'b000);
        check("R9 flags cleared", {enable_o, extref_o, ready_o, err_o}, 4'b0);
        check("R10 soft reset beats cal_done", cal_o, 1'b1);
        t_cal_done();
    endtask

    initial begin
        tick(3);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        tick(1);
        t_reset();
        t_cal_done();
        t_extref_first();
        t_power_up();
        t_repeat_on();
        t_enable_toggle();
        t_conv_ok();
        t_partial();
        t_power_cycle();
        t_softrst();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #(5 * 150000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule